// File: doc/BRIEF.md
# Prescaled Watchdog Down-Counter

This block guards a processor against runaway code. A programmable prescaler divides the bus clock. Each prescaler period produces a single-cycle enable, and on that enable a down-counter steps by one. The counter is loaded with all ones and counts toward zero. If software does not write the start strobe before the counter runs past zero, the block raises a one-cycle interrupt request and reloads the counter. The interrupt controller routes that request on.

The division ratio depends on two inputs. With the main oscillator as the bus clock source, a select bit picks a slow or a fast ratio, 128 or 16 by default. With the sub oscillator as the source, the ratio is always 2. After reset nothing counts until the first start write. The prescaler phase is cleared only by reset. A low-power halt input freezes both stages, and counting resumes from the frozen values when the halt is released. The full timeout is the ratio times 2^CNT_W bus clocks.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset, `count` is all ones (0x7FFF at the default width) and `irq` is 0. Both stay that way, with no counting, until the first cycle in which `start_wr` is 1.
- R2: A cycle with `start_wr` = 1 loads `count` with all ones at the next clock edge and enables counting from then on.
- R3: With `src_sub` = 0 and `div_sel` = 0, once counting, `count` decreases by one every 16 bus clocks.
- R4: With `src_sub` = 0 and `div_sel` = 1, once counting, `count` decreases by one every 128 bus clocks.
- R5: With `src_sub` = 1, `count` decreases by one every 2 bus clocks, whatever the value of `div_sel`.
- R6: When a prescaler enable arrives while `count` is 0, `count` reloads to all ones and `irq` is 1 in the following cycle.
- R7: `irq` is high for exactly one clock. Two successive requests with no start write between them are ratio × 2^CNT_W clocks apart (4096 for ratio 16 at CNT_W = 8).
- R8: A start write leaves the prescaler phase unchanged. After a start write made k clocks into a 16-clock prescaler period, the first decrement follows 16 − k − 1 clocks after the write edge.
- R9: While `halt` is 1 and `start_wr` is 0, neither `count` nor the prescaler phase changes and `irq` stays 0. After `halt` falls, counting resumes from the held values.
- R10: If `start_wr` is 1 in the same cycle as an underflow, the counter reloads once and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sub | input | 1 | Bus clock source: 1 = sub oscillator, 0 = main oscillator |
| div_sel | input | 1 | Main-oscillator ratio select: 0 = fast ratio (16), 1 = slow ratio (128) |
| start_wr | input | 1 | One-cycle strobe for a write to the start register |
| halt | input | 1 | Stop, wait or hold state is active; freezes the timer |
| irq | output | 1 | One-cycle watchdog interrupt request |
| count | output | CNT_W | Current counter value |

## Verification
On every cycle, the assertions check the local rules. The count only steps down by one or reloads to all ones. A request is a single-cycle pulse that follows a zero count and leaves the counter reloaded. A start write always reloads the counter without raising a request. A halt freezes the count and blocks requests. The block stays idle until the first start write. Some behaviour spans many cycles and only the bench's scenarios can show it: the exact spacing between decrements for each source and ratio setting, the full timeout period, the preserved prescaler phase across a start write, resumption after a halt, and the start-versus-underflow collision. The bench covers these with a reference model compared on every clock and with directed interval measurements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_SUB  = 1'b1
   } clk_src_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/wdog_ratio_sel.sv
module wdog_ratio_sel
   import wdog_pkg::*;
#(
   parameter int DIV_MAIN_LO = 16,
   parameter int DIV_MAIN_HI = 128,
   parameter int DIV_SUB     = 2,
   parameter int PW          = 7
) (
   input  clk_src_e        src,
   input  logic            div_sel,
   output logic [PW-1:0]   ratio_m1
);

   localparam logic [PW-1:0] LO_M1  = PW'(DIV_MAIN_LO - 1);
   localparam logic [PW-1:0] HI_M1  = PW'(DIV_MAIN_HI - 1);
   localparam logic [PW-1:0] SUB_M1 = PW'(DIV_SUB - 1);

   generate
      if (DIV_MAIN_LO == DIV_MAIN_HI) begin : g_single_main
         always_comb begin
            ratio_m1 = (src == SRC_SUB) ? SUB_M1 : LO_M1;
         end
      end else begin : g_dual_main
         always_comb begin
            if (src == SRC_SUB) begin
               ratio_m1 = SUB_M1;
            end else if (div_sel) begin
               ratio_m1 = HI_M1;
            end else begin
               ratio_m1 = LO_M1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int PW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] ratio_m1,
   output logic          tick
);

   logic [PW-1:0] phase;

   // ">=" keeps the wrap safe when the ratio shrinks mid-period
   assign tick = run && (phase >= ratio_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (run) begin
         phase <= tick ? '0 : phase + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             irq
);

   localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

   logic at_zero;
   assign at_zero = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= RELOAD;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (start_wr) begin
            count <= RELOAD;
         end else if (tick) begin
            if (at_zero) begin
               count <= RELOAD;
               irq   <= 1'b1;
            end else begin
               count <= count - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int CNT_W       = 15,
   parameter int DIV_MAIN_LO = 16,
   parameter int DIV_MAIN_HI = 128,
   parameter int DIV_SUB     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_sub,
   input  logic             div_sel,
   input  logic             start_wr,
   input  logic             halt,
   output logic             irq,
   output logic [CNT_W-1:0] count
);

   localparam int DIV_MAX = max_of3(DIV_MAIN_LO, DIV_MAIN_HI, DIV_SUB);
   localparam int PW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wdog_prescaled: CNT_W must lie in 2..32");
      end
      if (DIV_MAIN_LO < 2 || DIV_MAIN_HI < 2 || DIV_SUB < 2) begin : g_bad_ratio
         $error("wdog_prescaled: every prescaler ratio must be at least 2");
      end
   endgenerate

   logic          running;
   logic          tick;
   logic [PW-1:0] ratio_m1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (start_wr) begin
         running <= 1'b1;
      end
   end

   wdog_ratio_sel #(
      .DIV_MAIN_LO (DIV_MAIN_LO),
      .DIV_MAIN_HI (DIV_MAIN_HI),
      .DIV_SUB     (DIV_SUB),
      .PW          (PW)
   ) i_ratio (
      .src      (clk_src_e'(src_sub)),
      .div_sel  (div_sel),
      .ratio_m1 (ratio_m1)
   );

   wdog_prescaler #(
      .PW (PW)
   ) i_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running && !halt),
      .ratio_m1 (ratio_m1),
      .tick     (tick)
   );

   wdog_downcount #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (start_wr),
      .tick     (tick),
      .count    (count),
      .irq      (irq)
   );

endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_wr,
   input logic             halt,
   input logic             irq,
   input logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

   logic seen_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_start <= 1'b0;
      end else if (start_wr) begin
         seen_start <= 1'b1;
      end
   end

   AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_start |-> (count == RELOAD) && !irq); // R1

   AST_START_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (count == RELOAD)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ((count == $past(count) - 1'b1) || (count == RELOAD))); // R3

   AST_IRQ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(count) == '0) && (count == RELOAD)); // R6

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !start_wr) |=> $stable(count) && !irq); // R9

   AST_START_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> !irq); // R10

endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_wr (start_wr),
   .halt     (halt),
   .irq      (irq),
   .count    (count)
);

// File: tb/test_wdog_prescaled.sv
module test_wdog_prescaled;

   localparam int W      = 8;
   localparam int RELOAD = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_sub = 1'b0;
   logic         div_sel = 1'b0;
   logic         start_wr = 1'b0;
   logic         halt = 1'b0;
   logic         irq;
   logic [W-1:0] count;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   wdog_prescaled #(.CNT_W(W)) i_wdog_prescaled (
      .clk (clk), .rst_n (rst_n), .src_sub (src_sub), .div_sel (div_sel),
      .start_wr (start_wr), .halt (halt), .irq (irq), .count (count)
   );

   // behavioural reference model
   int m_run, m_pre, m_cnt, m_irq;
   always @(posedge clk) begin
      int ratio, tk, nirq;
      if (!rst_n) begin
         m_run = 0; m_pre = 0; m_cnt = RELOAD; m_irq = 0;
      end else begin
         ratio = src_sub ? 2 : (div_sel ? 128 : 16);
         tk    = (m_run != 0 && !halt && m_pre >= ratio - 1) ? 1 : 0;
         nirq  = 0;
         if (m_run != 0 && !halt) m_pre = tk ? 0 : m_pre + 1;
         if (start_wr) begin
            m_cnt = RELOAD; m_run = 1;
         end else if (tk != 0) begin
            if (m_cnt == 0) begin m_cnt = RELOAD; nirq = 1; end
            else m_cnt = m_cnt - 1;
         end
         m_irq = nirq;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         check("R2/R6 model count", int'(count), m_cnt);
         check("R6/R7 model irq", int'(irq), m_irq);
      end
      if (cycles > 150000 && !done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic pulse_start();
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
   endtask

   // cycles between two consecutive count changes
   task automatic step_gap(output int gap);
      logic [W-1:0] v;
      v = count;
      while (count == v) @(negedge clk);
      v = count; gap = 0;
      while (count == v) begin @(negedge clk); gap++; end
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq) begin @(negedge clk); n++; end
   endtask

   initial begin
      int g, n, held;
      repeat (3) @(negedge clk);
      check("R1 reset count", int'(count), RELOAD);
      check("R1 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      repeat (60) @(negedge clk);
      check("R1 idle count", int'(count), RELOAD);

      // sub oscillator, div_sel set but ignored
      src_sub = 1'b1; div_sel = 1'b1;
      pulse_start();
      check("R2 start reload", int'(count), RELOAD);
      step_gap(g);
      check("R5 sub gap", g, 2);

      wait_irq(n);
      check("R6 reload on underflow", int'(count), RELOAD);
      @(negedge clk);
      check("R7 irq width", int'(irq), 0);
      wait_irq(n);
      check("R7 sub period", n + 1, 2 * 256);

      // main, fast ratio
      src_sub = 1'b0; div_sel = 1'b0;
      step_gap(g);
      check("R3 fast gap", g, 16);
      wait_irq(n);
      @(negedge clk);
      wait_irq(n);
      check("R7 fast period", n + 1, 16 * 256);

      // prescaler phase preserved across start
      step_gap(g);
      repeat (5) @(negedge clk);
      pulse_start();
      n = 1;
      while (count == RELOAD) begin @(negedge clk); n++; end
      check("R8 phase kept", n - 1, 10);

      // main, slow ratio
      div_sel = 1'b1;
      step_gap(g);
      check("R4 slow gap", g, 128);

      // halt freeze and resume
      src_sub = 1'b1;
      step_gap(g);
      halt = 1'b1;
      @(negedge clk);
      held = int'(count);
      repeat (20) @(negedge clk);
      check("R9 halt hold", int'(count), held);
      check("R9 halt irq", int'(irq), 0);
      halt = 1'b0;
      while (int'(count) == held) @(negedge clk);
      check("R9 resume", int'(count), held - 1);

      // start collides with underflow
      while (count != 0) @(negedge clk);
      @(negedge clk);
      pulse_start();
      check("R10 collision count", int'(count), RELOAD);
      check("R10 collision irq", int'(irq), 0);
      @(negedge clk);
      check("R10 no late irq", int'(irq), 0);

      repeat (5) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule